// File: doc/BRIEF.md
# Sixteen-Bit Auto-Reload Timer/Counter

This peripheral holds a 16-bit count that advances on enabled count steps. When the count is at all-ones, the next step loads the count from a separate 16-bit reload pair and raises an overflow flag. The overflow flag drives an interrupt request. The reload pair is only ever changed by software. A step comes from one of two sources, selected by a control bit. The first is a free-running divide-by-12 machine-cycle tick. The second is a falling transition on an external count pin, sampled once per machine cycle. Counting needs a run bit. It can also be qualified by the level of the first external-interrupt pin.

The same 8-bit control register holds the sensing mode and the pending flag for two external-interrupt pins. A pin in edge mode latches a falling edge until it is acknowledged. A pin in level mode makes its flag follow the inverted pin level. Software reaches five byte registers over a simple single-cycle bus. Writes take effect at the clock edge. Reads come back combinationally.

Top module: `reload_tmr16`

## Requirements
- R1: While reset is asserted, all registers read as zero and `tmr_irq`, `x0_req` and `x1_req` are 0.
- R2: Register map: address 0 is control, 1 and 2 are the count low and high bytes, 3 and 4 are the reload low and high bytes. Control bits are: 7 gate enable, 6 source select (1 = pin), 5 overflow flag, 4 run, 3 pin-0 flag, 2 pin-0 edge mode, 1 pin-1 flag, 0 pin-1 edge mode. Written values read back.
- R3: With run=1, gate enable=0 and source select=0, the count rises by exactly N over any 12·N consecutive clock edges. With run=0 it holds.
- R4: A step taken at count 0xFFFF loads the reload pair into the count. The reload pair keeps its value.
- R5: A wrap sets the overflow flag. `tmr_irq` is 1 exactly when the flag and `irq_en` are both 1.
- R6: A `tmr_ack` pulse clears the overflow flag. A wrap in the same cycle wins.
- R7: With gate enable=1, no step happens while `pin_x0` is low. Steps resume while it is high.
- R8: With source select=1, each high-to-low change of `pin_cnt` seen between two successive machine-cycle samples gives one step. Rising changes give none.
- R9: A write to a count byte replaces that byte. It also cancels any step on that edge, so the other byte is unchanged.
- R10: Writing the reload pair leaves the current count unchanged.
- R11: In edge mode, a falling edge on a pin sets its flag. The flag stays set until that pin's acknowledge input is pulsed.
- R12: In level mode, a pin's flag equals the inverse of the synchronised pin level. Acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_cnt | input | 1 | External count pin |
| pin_x0 | input | 1 | External interrupt pin 0, also the gate input |
| pin_x1 | input | 1 | External interrupt pin 1 |
| irq_en | input | 1 | Enables the timer interrupt request |
| tmr_ack | input | 1 | Timer interrupt acknowledge |
| x0_ack | input | 1 | Pin-0 interrupt acknowledge |
| x1_ack | input | 1 | Pin-1 interrupt acknowledge |
| tmr_irq | output | 1 | Timer interrupt request |
| x0_req | output | 1 | Pin-0 flag |
| x1_req | output | 1 | Pin-1 flag |

## Verification
The hardest case to reach from the ports is a count-byte write that lands on the same edge as a prescaler step. The prescaler runs freely and its phase cannot be observed. The bench therefore writes 0xFF to the low byte on thirteen back-to-back edges while the timer runs. At least one of those edges must carry a step, and the high byte must still read zero. Exact count checks use run windows of whole multiples of twelve edges, so they do not depend on the prescaler phase.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;

    // Control register, most significant bit first.
    typedef struct packed {
        logic gate_en;   // step only while pin 0 is high
        logic src_ext;   // 1: count pin falling edges, 0: machine-cycle tick
        logic ovf;       // overflow flag
        logic run;       // run enable
        logic x0_hit;    // pin-0 pending flag
        logic x0_edge;   // pin-0 edge mode
        logic x1_hit;    // pin-1 pending flag
        logic x1_edge;   // pin-1 edge mode
    } tctrl_t;

    localparam int unsigned CTRL_W = $bits(tctrl_t);

endpackage

// File: rtl/rtmr_sync.sv
`timescale 1ns/1ps
module rtmr_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            sh_d[s] = sh_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rtmr_edge.sv
`timescale 1ns/1ps
module rtmr_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_fall
        assign fall[i] = prev_q[i] & ~din[i];
    end
endmodule

// File: rtl/rtmr_src.sv
`timescale 1ns/1ps
module rtmr_src #(
    parameter int unsigned PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic pin_s,
    output logic src_pulse
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] div;
        logic          samp;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    mc_tick;
    logic    pin_fall;

    always_comb begin
        st_d     = st_q;
        mc_tick  = (st_q.div == LAST);
        pin_fall = mc_tick && st_q.samp && !pin_s;
        if (mc_tick) begin
            st_d.div  = '0;
            st_d.samp = pin_s;
        end else begin
            st_d.div  = st_q.div + PW'(1);
        end
        src_pulse = src_ext ? pin_fall : mc_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/reload_tmr16.sv
`timescale 1ns/1ps
module reload_tmr16 #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PRESCALE    = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pin_cnt,
    input  logic       pin_x0,
    input  logic       pin_x1,
    input  logic       irq_en,
    input  logic       tmr_ack,
    input  logic       x0_ack,
    input  logic       x1_ack,
    output logic       tmr_irq,
    output logic       x0_req,
    output logic       x1_req
);
    import rtmr_pkg::*;

    localparam int unsigned BYTES  = CNT_W / 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned N_PINS = 3;

    typedef struct packed {
        tctrl_t           ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic [N_PINS-1:0] pins_s;
    logic [1:0]        x_fall;
    logic              src_pulse;
    logic              gate_ok, step, at_max, wrap;
    logic              ctrl_wr, cnt_wr, rld_wr;

    rtmr_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_cnt, pin_x1, pin_x0}),
        .dout (pins_s)
    );

    rtmr_edge #(.N(2)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_s[1:0]),
        .fall (x_fall)
    );

    rtmr_src #(.PRESCALE(PRESCALE)) src_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_ext  (st_q.ctrl.src_ext),
        .pin_s    (pins_s[2]),
        .src_pulse(src_pulse)
    );

    assign ctrl_wr = bus_wr && (bus_addr == '0);
    assign cnt_wr  = bus_wr && (bus_addr >= ADDR_W'(1)) && (bus_addr <= ADDR_W'(BYTES));
    assign rld_wr  = bus_wr && (bus_addr >= ADDR_W'(BYTES + 1))
                            && (bus_addr <= ADDR_W'(2 * BYTES));

    always_comb begin
        st_d    = st_q;
        gate_ok = !st_q.ctrl.gate_en || pins_s[0];
        step    = st_q.ctrl.run && gate_ok && src_pulse;
        at_max  = &st_q.cnt;
        wrap    = step && at_max && !cnt_wr;

        // count: a software write cancels the step on that edge
        if (cnt_wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (bus_addr == ADDR_W'(b + 1)) st_d.cnt[b*8 +: 8] = bus_wdata;
            end
        end else if (step) begin
            st_d.cnt = at_max ? st_q.rld : st_q.cnt + CNT_W'(1);
        end

        // reload pair: software only
        if (rld_wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (bus_addr == ADDR_W'(BYTES + 1 + b)) st_d.rld[b*8 +: 8] = bus_wdata;
            end
        end

        // control and flags: a software write wins over hardware updates
        if (ctrl_wr) begin
            st_d.ctrl = tctrl_t'(bus_wdata);
        end else begin
            if (wrap)         st_d.ctrl.ovf = 1'b1;
            else if (tmr_ack) st_d.ctrl.ovf = 1'b0;

            if (st_q.ctrl.x0_edge) begin
                if (x_fall[0])   st_d.ctrl.x0_hit = 1'b1;
                else if (x0_ack) st_d.ctrl.x0_hit = 1'b0;
            end else begin
                st_d.ctrl.x0_hit = !pins_s[0];
            end

            if (st_q.ctrl.x1_edge) begin
                if (x_fall[1])   st_d.ctrl.x1_hit = 1'b1;
                else if (x1_ack) st_d.ctrl.x1_hit = 1'b0;
            end else begin
                st_d.ctrl.x1_hit = !pins_s[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = st_q.ctrl;
        for (int b = 0; b < BYTES; b++) begin
            if (bus_addr == ADDR_W'(b + 1))         bus_rdata = st_q.cnt[b*8 +: 8];
            if (bus_addr == ADDR_W'(BYTES + 1 + b)) bus_rdata = st_q.rld[b*8 +: 8];
        end
    end

    assign tmr_irq = st_q.ctrl.ovf && irq_en;
    assign x0_req  = st_q.ctrl.x0_hit;
    assign x1_req  = st_q.ctrl.x1_hit;
endmodule

// File: rtl/rtmr_chk.sv
`timescale 1ns/1ps
module rtmr_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic             cnt_wr,
    input logic             rld_wr,
    input logic             ctrl_wr,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rld_q,
    input rtmr_pkg::tctrl_t ctrl_q,
    input logic             tmr_ack,
    input logic             x0_ack,
    input logic             x0_s,
    input logic             tmr_irq
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr) |=> $stable(cnt_q));

    p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && (&cnt_q)) |=> (cnt_q == $past(rld_q)));

    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && (&cnt_q) && !ctrl_wr) |=> ctrl_q.ovf);

    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> ctrl_q.ovf);

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ack && !ctrl_wr && !(step && !cnt_wr && (&cnt_q))) |=> !ctrl_q.ovf);

    p_rld_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rld_wr |=> $stable(rld_q));

    p_edge_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.x0_edge && ctrl_q.x0_hit && !x0_ack && !ctrl_wr) |=> ctrl_q.x0_hit);

    p_level_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.x0_edge && !ctrl_wr) |=> (ctrl_q.x0_hit == !$past(x0_s)));
endmodule

bind reload_tmr16 rtmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .cnt_wr (cnt_wr),
    .rld_wr (rld_wr),
    .ctrl_wr(ctrl_wr),
    .cnt_q  (st_q.cnt),
    .rld_q  (st_q.rld),
    .ctrl_q (st_q.ctrl),
    .tmr_ack(tmr_ack),
    .x0_ack (x0_ack),
    .x0_s   (pins_s[0]),
    .tmr_irq(tmr_irq)
);

// File: tb/reload_tmr16_tb_top.sv
`timescale 1ns/1ps
module reload_tmr16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_cnt = 1'b0, pin_x0 = 1'b1, pin_x1 = 1'b1;
    logic       irq_en = 1'b1, tmr_ack = 1'b0, x0_ack = 1'b0, x1_ack = 1'b0;
    logic       tmr_irq, x0_req, x1_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    reload_tmr16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_cnt(pin_cnt),
        .pin_x0(pin_x0), .pin_x1(pin_x1), .irq_en(irq_en), .tmr_ack(tmr_ack),
        .x0_ack(x0_ack), .x1_ack(x1_ack), .tmr_irq(tmr_irq), .x0_req(x0_req),
        .x1_req(x1_req)
    );

    typedef struct packed {
        logic [15:0] rld;
        logic [15:0] pre;
        logic [7:0]  n_mc;
        logic [15:0] exp_cnt;
        logic        exp_tf;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{16'h0000, 16'h0000, 8'd5,  16'h0005, 1'b0},
        '{16'h1234, 16'hFFFE, 8'd3,  16'h1235, 1'b1},
        '{16'hABCD, 16'hFFFF, 8'd2,  16'hABCE, 1'b1},
        '{16'hFFFF, 16'hFFFF, 8'd3,  16'hFFFF, 1'b1},
        '{16'h8000, 16'h00FF, 8'd2,  16'h0101, 1'b0},
        '{16'h0000, 16'hFFF0, 8'd20, 16'h0004, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // all bus tasks are entered at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  d;
        logic [15:0] w;

        // R1: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 reset register", d, 8'h00);
        end
        check("R1 reset outputs", {tmr_irq, x0_req, x1_req}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R3 R4 R5: vector table in timer mode
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, 8'h00);
            wr16(3'd3, VECS[i].rld);
            wr16(3'd1, VECS[i].pre);
            wr(3'd0, 8'h10);
            repeat (12 * int'(VECS[i].n_mc) - 1) @(negedge clk);
            check($sformatf("R5 irq vector %0d", i), tmr_irq, VECS[i].exp_tf);
            wr(3'd0, 8'h00);
            rd16(3'd1, w);
            check($sformatf("R3 R4 count vector %0d", i), w, VECS[i].exp_cnt);
            rd16(3'd3, w);
            check($sformatf("R4 reload kept vector %0d", i), w, VECS[i].rld);
        end

        // R2: control register read back
        wr(3'd0, 8'h44);
        rd(3'd0, d);
        check("R2 control readback", d & 8'hF5, 8'h44);
        wr(3'd0, 8'h00);

        // R10: reload write leaves count alone
        wr16(3'd1, 16'h0010);
        wr16(3'd3, 16'h55AA);
        rd16(3'd1, w);
        check("R10 count after reload write", w, 16'h0010);

        // R9: byte write wins over a step on the same edge
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h10);
        for (int k = 0; k < 13; k++) begin
            wr(3'd1, 8'hFF);
            rd(3'd1, d);
            if (d !== 8'hFF) check("R9 low byte written", d, 8'hFF);
        end
        rd(3'd1, d);
        check("R9 low byte final", d, 8'hFF);
        rd(3'd2, d);
        check("R9 high byte untouched", d, 8'h00);
        wr(3'd0, 8'h00);

        // R7: gate qualification
        wr16(3'd1, 16'h0000);
        pin_x0 = 1'b0;
        repeat (4) @(negedge clk);
        wr(3'd0, 8'h90);
        repeat (60) @(negedge clk);
        rd16(3'd1, w);
        check("R7 gated off", w, 16'h0000);
        pin_x0 = 1'b1;
        repeat (120) @(negedge clk);
        rd16(3'd1, w);
        check_rng("R7 gated on", int'(w), 9, 10);
        wr(3'd0, 8'h00);
        pin_x0 = 1'b0;
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h10);
        repeat (12 * 4 - 1) @(negedge clk);
        wr(3'd0, 8'h00);
        rd16(3'd1, w);
        check("R7 gate off ignores pin", w, 16'h0004);
        pin_x0 = 1'b1;
        repeat (4) @(negedge clk);

        // R8: counting falling edges of the count pin
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h50);
        for (int k = 0; k < 5; k++) begin
            pin_cnt = 1'b1;
            repeat (36) @(negedge clk);
            if (k == 0) begin
                rd16(3'd1, w);
                check("R8 rising edge ignored", w, 16'h0000);
            end
            pin_cnt = 1'b0;
            repeat (36) @(negedge clk);
        end
        rd16(3'd1, w);
        check("R8 falling edges counted", w, 16'h0005);
        wr(3'd0, 8'h00);

        // R5 R6: flag, enable and acknowledge
        wr16(3'd3, 16'h0000);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h10);
        repeat (24) @(negedge clk);
        check("R5 irq on overflow", tmr_irq, 1'b1);
        irq_en = 1'b0;
        #1;
        check("R5 irq masked", tmr_irq, 1'b0);
        rd(3'd0, d);
        check("R5 flag still set", d[5], 1'b1);
        tmr_ack = 1'b1;
        @(negedge clk);
        tmr_ack = 1'b0;
        rd(3'd0, d);
        check("R6 flag cleared by ack", d[5], 1'b0);
        irq_en = 1'b1;
        wr(3'd0, 8'h00);

        // R11: edge mode
        wr(3'd0, 8'h05);
        repeat (4) @(negedge clk);
        rd(3'd0, d);
        check("R11 flags idle", {d[3], d[1]}, 2'b00);
        pin_x0 = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 pin0 edge latched", x0_req, 1'b1);
        pin_x0 = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 pin0 sticky", x0_req, 1'b1);
        x0_ack = 1'b1;
        @(negedge clk);
        x0_ack = 1'b0;
        check("R11 pin0 ack clears", x0_req, 1'b0);
        pin_x1 = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 pin1 edge latched", x1_req, 1'b1);
        x1_ack = 1'b1;
        @(negedge clk);
        x1_ack = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 pin1 low level no retrigger", x1_req, 1'b0);
        pin_x1 = 1'b1;
        repeat (4) @(negedge clk);

        // R12: level mode
        wr(3'd0, 8'h00);
        repeat (4) @(negedge clk);
        check("R12 level idle", x1_req, 1'b0);
        pin_x1 = 1'b0;
        repeat (5) @(negedge clk);
        check("R12 level tracks low", x1_req, 1'b1);
        x1_ack = 1'b1;
        @(negedge clk);
        x1_ack = 1'b0;
        check("R12 ack ignored", x1_req, 1'b1);
        pin_x1 = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 level tracks high", x1_req, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule